// File: doc/BRIEF.md
# Shared Sample Timebase and Trigger Unit

This unit gives a group of boards one sample clock and one time count. Every board carries a copy, and the slot address decides which copy is the master. The master builds a 2 MHz sample tick. It takes the tick from an external reference while that reference is healthy and from an internal divider of the system clock otherwise. It also qualifies an external trigger and a software trigger request. It drives the tick and the trigger onto the backplane as a clock line and an active-low trigger line.

Every board, the master included, listens only to the backplane copies. A rising edge on the backplane clock line is one sample tick and advances a 32-bit timestamp. A falling edge on the backplane trigger line zeroes that timestamp on all boards at the same moment. The master decides when to change source. It changes only on a tick boundary, and a status output tells which source is in use.

Top module: `tbu_timebase`

## Requirements
- R1: After each cycle in which `tick_o` is 1, `timestamp_o` is one higher in the next cycle, modulo 2^32. In a cycle with no tick and no clear it does not change.
- R2: On the master, with no usable external reference, `tick_o` pulses exactly every TICK_DIV = 50 system clocks, which is 500 ns at 100 MHz.
- R3: A falling edge on `bp_trig_n_i`, after synchronisation, makes `timestamp_o` zero in the next cycle. This holds even when a tick occurs in the same cycle.
- R4: On the master, a low pulse on `ext_trig_n_i` is accepted once it has stayed low for TRIG_MIN_CYC = 50 consecutive system clocks (500 ns). A shorter pulse is ignored. A long low level gives one acceptance only, and the line must return high before it can trigger again. Each acceptance drives `bp_trig_n_o` low for TRIG_OUT_CYC = 4 cycles, which is one falling edge.
- R5: On the master, a rising edge of `sw_trig_i` gives exactly one backplane trigger pulse, however long the request stays high.
- R6: The external reference `ext_ref_i` is taken as present after 16 consecutive rising-edge intervals, each shorter than LOSS_CYC = 200 cycles. The switch to it happens at the next internal tick. After that, `ext_sel_o` = 1 and ticks follow the reference's rising edges.
- R7: When no rising edge of the reference arrives for LOSS_CYC = 200 cycles, the master returns to the internal divider (`ext_sel_o` = 0). The internal ticks then resume at the TICK_DIV period.
- R8: The source changes only at a tick. On the master, two generated ticks are never closer together than TICK_DIV/2 = 25 cycles.
- R9: `master_o` is 1 exactly when `slot_addr_i` equals MASTER_SLOT = 3.
- R10: On a non-master board, `bp_clk_o` stays 0 and `bp_trig_n_o` stays 1. Its external trigger and software trigger have no effect on the timestamp. Its ticks follow `bp_clk_i`.
- R11: Every asynchronous input passes through two synchroniser flops before any edge detection. During reset, `timestamp_o` = 0, `tick_o` = 0, `ext_sel_o` = 0, `bp_clk_o` = 0 and `bp_trig_n_o` = 1. A tick is always a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_addr_i | input | SLOT_W | Logical slot number from the hardware address |
| ext_ref_i | input | 1 | External 2 MHz reference, asynchronous |
| ext_trig_n_i | input | 1 | External trigger, active low, asynchronous |
| sw_trig_i | input | 1 | Software trigger request |
| bp_clk_i | input | 1 | Backplane sample clock as received |
| bp_trig_n_i | input | 1 | Backplane trigger as received, active low |
| tick_o | output | 1 | One-cycle sample tick |
| timestamp_o | output | TS_W | Shared time count |
| ext_sel_o | output | 1 | 1 when the external reference is the tick source |
| master_o | output | 1 | This board sources clock and trigger |
| bp_clk_o | output | 1 | Sample clock driven to the backplane (master only) |
| bp_trig_n_o | output | 1 | Trigger driven to the backplane, active low (master only) |

## Verification
The internal source is timed with no reference present (50-cycle spacing). The external source is timed with a 60-cycle reference, so a 60-cycle spacing can only come from the external path. Removing the reference must bring back 50-cycle spacing, and the stamp after each change shows no short tick. Trigger widths are drawn at random around the 50-cycle limit, with directed widths of 49 and 50, a held-low level and held software requests. These separate a single accepted pulse, a rejected pulse and a duplicated acceptance. A slave phase drives the backplane lines from the bench at a 40-cycle period and pulses the local triggers. This shows that local stimulus is ignored and that the backplane alone sets the ticks and clears.

// File: rtl/tbu_pkg.sv
package tbu_pkg;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } ref_src_e;

    typedef struct packed {
        logic tick;
        logic clear;
    } stamp_evt_t;

    localparam int SYNC_N      = 4;
    localparam int SI_REF      = 0;
    localparam int SI_TRIG     = 1;
    localparam int SI_BPCLK    = 2;
    localparam int SI_BPTRIG   = 3;

    // reset levels of the synchronisers: idle-high trigger lines, idle-low clocks
    localparam logic [SYNC_N-1:0] SYNC_IDLE = 4'b1010;

endpackage

// File: rtl/tbu_sync.sv
module tbu_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
            s3_q <= RST_VAL;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign lvl  = s2_q;
    assign rise = s2_q & ~s3_q;
    assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/tbu_ref_monitor.sv
module tbu_ref_monitor #(
    parameter int LOSS_CYC   = 200,
    parameter int GOOD_EDGES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_rise,
    output logic ref_ok
);
    localparam int GW = $clog2(LOSS_CYC + 1);
    localparam int CW = $clog2(GOOD_EDGES + 1);

    logic [GW-1:0] gap_q;
    logic [CW-1:0] good_q;
    logic          ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= GW'(LOSS_CYC);
            good_q <= '0;
            ok_q   <= 1'b0;
        end else if (ref_rise) begin
            gap_q <= '0;
            if (gap_q < GW'(LOSS_CYC)) begin
                if (good_q == CW'(GOOD_EDGES - 1))
                    ok_q <= 1'b1;
                else
                    good_q <= good_q + 1'b1;
            end else begin
                good_q <= '0;
            end
        end else if (gap_q != GW'(LOSS_CYC)) begin
            gap_q <= gap_q + 1'b1;
            if (gap_q == GW'(LOSS_CYC - 1)) begin
                ok_q   <= 1'b0;
                good_q <= '0;
            end
        end
    end

    assign ref_ok = ok_q;
endmodule

// File: rtl/tbu_tick_gen.sv
module tbu_tick_gen
    import tbu_pkg::*;
#(
    parameter int TICK_DIV = 50,
    parameter int MIN_GAP  = 25,
    parameter int HIGH_CYC = 12
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ext_rise,
    input  logic     ext_ok,
    output logic     mtick,
    output ref_src_e src,
    output logic     clk_out
);
    localparam int DW = $clog2(TICK_DIV);
    localparam int HW = $clog2(HIGH_CYC + 1);

    logic [DW-1:0] div_q;
    logic [HW-1:0] hi_q;
    ref_src_e      src_q;
    logic          clk_q;
    logic          int_due, gap_ok;

    always_comb begin
        int_due = (div_q == DW'(TICK_DIV - 1));
        gap_ok  = (div_q >= DW'(MIN_GAP));
        if (src_q == SRC_EXT)
            mtick = ext_rise && ext_ok && gap_ok;
        else
            mtick = int_due;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            hi_q  <= '0;
            src_q <= SRC_INT;
            clk_q <= 1'b0;
        end else begin
            if (mtick)
                div_q <= '0;
            else if (!int_due)
                div_q <= div_q + 1'b1;

            if (src_q == SRC_EXT && !ext_ok)
                src_q <= SRC_INT;
            else if (src_q == SRC_INT && int_due && ext_ok)
                src_q <= SRC_EXT;

            if (mtick) begin
                clk_q <= 1'b1;
                hi_q  <= HW'(HIGH_CYC - 1);
            end else if (hi_q != '0) begin
                hi_q <= hi_q - 1'b1;
            end else begin
                clk_q <= 1'b0;
            end
        end
    end

    assign src     = src_q;
    assign clk_out = clk_q;
endmodule

// File: rtl/tbu_trig_qual.sv
module tbu_trig_qual #(
    parameter int MIN_LOW = 50,
    parameter int OUT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_lvl,
    input  logic sw_req,
    input  logic enable,
    output logic trig_n
);
    localparam int LW = $clog2(MIN_LOW);
    localparam int OW = $clog2(OUT_CYC + 1);

    logic [LW-1:0] low_q;
    logic [OW-1:0] out_q;
    logic          armed_q, sw_q;
    logic          accept, sw_pulse, fire;

    assign accept   = armed_q && !trig_lvl && (low_q == LW'(MIN_LOW - 1));
    assign sw_pulse = sw_req && !sw_q;
    assign fire     = enable && (accept || sw_pulse);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q   <= '0;
            out_q   <= '0;
            armed_q <= 1'b0;
            sw_q    <= 1'b0;
        end else begin
            sw_q <= sw_req;
            if (trig_lvl) begin
                armed_q <= 1'b1;
                low_q   <= '0;
            end else if (armed_q) begin
                if (accept) begin
                    armed_q <= 1'b0;
                    low_q   <= '0;
                end else begin
                    low_q <= low_q + 1'b1;
                end
            end
            if (fire)
                out_q <= OW'(OUT_CYC);
            else if (out_q != '0)
                out_q <= out_q - 1'b1;
        end
    end

    assign trig_n = (out_q == '0);
endmodule

// File: rtl/tbu_timebase.sv
module tbu_timebase
    import tbu_pkg::*;
#(
    parameter int SLOT_W       = 4,
    parameter int MASTER_SLOT  = 3,
    parameter int TS_W         = 32,
    parameter int TICK_DIV     = 50,
    parameter int TRIG_MIN_CYC = 50,
    parameter int LOSS_CYC     = 200,
    parameter int GOOD_EDGES   = 16,
    parameter int TRIG_OUT_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] slot_addr_i,
    input  logic              ext_ref_i,
    input  logic              ext_trig_n_i,
    input  logic              sw_trig_i,
    input  logic              bp_clk_i,
    input  logic              bp_trig_n_i,
    output logic              tick_o,
    output logic [TS_W-1:0]   timestamp_o,
    output logic              ext_sel_o,
    output logic              master_o,
    output logic              bp_clk_o,
    output logic              bp_trig_n_o
);
    localparam int MIN_GAP  = TICK_DIV / 2;
    localparam int HIGH_CYC = TICK_DIV / 4;

    logic [SYNC_N-1:0] s_lvl, s_rise, s_fall;
    logic              ref_ok, m_tick, gen_clk, qual_n, is_master;
    ref_src_e          src;
    stamp_evt_t        evt;
    logic              evt_tick, evt_clear;
    logic [TS_W-1:0]   stamp_q;

    tbu_sync #(.W(SYNC_N), .RST_VAL(SYNC_IDLE)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({bp_trig_n_i, bp_clk_i, ext_trig_n_i, ext_ref_i}),
        .lvl (s_lvl),
        .rise(s_rise),
        .fall(s_fall)
    );

    tbu_ref_monitor #(.LOSS_CYC(LOSS_CYC), .GOOD_EDGES(GOOD_EDGES)) mon_i (
        .clk     (clk),
        .rst     (rst),
        .ref_rise(s_rise[SI_REF]),
        .ref_ok  (ref_ok)
    );

    tbu_tick_gen #(.TICK_DIV(TICK_DIV), .MIN_GAP(MIN_GAP), .HIGH_CYC(HIGH_CYC)) gen_i (
        .clk     (clk),
        .rst     (rst),
        .ext_rise(s_rise[SI_REF]),
        .ext_ok  (ref_ok),
        .mtick   (m_tick),
        .src     (src),
        .clk_out (gen_clk)
    );

    tbu_trig_qual #(.MIN_LOW(TRIG_MIN_CYC), .OUT_CYC(TRIG_OUT_CYC)) qual_i (
        .clk     (clk),
        .rst     (rst),
        .trig_lvl(s_lvl[SI_TRIG]),
        .sw_req  (sw_trig_i),
        .enable  (is_master),
        .trig_n  (qual_n)
    );

    assign is_master = (slot_addr_i == SLOT_W'(MASTER_SLOT));

    always_comb begin
        evt.tick  = s_rise[SI_BPCLK];
        evt.clear = s_fall[SI_BPTRIG];
    end
    assign evt_tick  = evt.tick;
    assign evt_clear = evt.clear;

    always_ff @(posedge clk) begin
        if (rst)
            stamp_q <= '0;
        else if (evt.clear)
            stamp_q <= '0;
        else if (evt.tick)
            stamp_q <= stamp_q + 1'b1;
    end

    assign tick_o      = evt.tick;
    assign timestamp_o = stamp_q;
    assign ext_sel_o   = (src == SRC_EXT);
    assign master_o    = is_master;
    assign bp_clk_o    = is_master & gen_clk;
    assign bp_trig_n_o = ~is_master | qual_n;
endmodule

// File: rtl/tbu_timebase_chk.sv
module tbu_timebase_chk #(
    parameter int TS_W    = 32,
    parameter int MIN_GAP = 25
) (
    input logic            clk,
    input logic            rst,
    input logic            tick,
    input logic            clear,
    input logic            mtick,
    input logic [TS_W-1:0] stamp,
    input logic            ext_sel,
    input logic            master,
    input logic            bp_clk,
    input logic            bp_trig_n
);
    localparam int GW = $clog2(MIN_GAP + 1);

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (mtick) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != GW'(MIN_GAP)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    p_count_r1: assert property (@(posedge clk) disable iff (rst)
        tick && !clear |=> stamp == $past(stamp) + TS_W'(1));

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !tick && !clear |=> stamp == $past(stamp));

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        clear |=> stamp == '0);

    p_switch_at_tick_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_sel) |-> $past(mtick));

    p_min_gap_r8: assert property (@(posedge clk) disable iff (rst)
        mtick && seen_q |-> gap_q >= GW'(MIN_GAP));

    p_slave_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !master |-> !bp_clk && bp_trig_n);

    p_tick_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

bind tbu_timebase tbu_timebase_chk #(.TS_W(TS_W), .MIN_GAP(MIN_GAP)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (evt_tick),
    .clear    (evt_clear),
    .mtick    (m_tick),
    .stamp    (timestamp_o),
    .ext_sel  (ext_sel_o),
    .master   (master_o),
    .bp_clk   (bp_clk_o),
    .bp_trig_n(bp_trig_n_o)
);

// File: tb/tbu_timebase_tb_top.sv
module tbu_timebase_tb_top;
    localparam int TICK_DIV = 50;
    localparam int TRIG_MIN = 50;
    localparam int EXT_PER  = 60;
    localparam int BP_PER   = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  slot = 4'd3;
    logic        ext_ref = 1'b0;
    logic        ext_trig_n = 1'b1;
    logic        sw_trig = 1'b0;
    logic        tb_bp_clk = 1'b0;
    logic        tb_bp_trig_n = 1'b1;
    logic        slave_mode = 1'b0;
    logic        bp_clk_i, bp_trig_n_i;
    logic        tick, ext_sel, master, bp_clk_o, bp_trig_n_o;
    logic [31:0] ts;

    always #5 clk = ~clk;

    assign bp_clk_i    = slave_mode ? tb_bp_clk : bp_clk_o;
    assign bp_trig_n_i = slave_mode ? tb_bp_trig_n : bp_trig_n_o;

    tbu_timebase dut_i (
        .clk(clk), .rst(rst), .slot_addr_i(slot), .ext_ref_i(ext_ref),
        .ext_trig_n_i(ext_trig_n), .sw_trig_i(sw_trig), .bp_clk_i(bp_clk_i),
        .bp_trig_n_i(bp_trig_n_i), .tick_o(tick), .timestamp_o(ts),
        .ext_sel_o(ext_sel), .master_o(master), .bp_clk_o(bp_clk_o),
        .bp_trig_n_o(bp_trig_n_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int unsigned cyc = 0;
    bit ext_on = 1'b0;
    bit bp_on = 1'b0;
    int ext_ph = 0;
    int bp_ph = 0;
    bit mon_on = 1'b0;
    bit track = 1'b0;
    int clears = 0;
    int trig_falls = 0;
    int min_gap = 1000000;
    int last_tick_cyc = -1;
    logic        prev_tick = 1'b0;
    logic        prev_bpt = 1'b1;
    logic [31:0] prev_ts = '0;
    logic [31:0] exp_ts;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int trig_expect(input int width);
        return (width >= TRIG_MIN) ? 1 : 0;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    initial forever begin
        @(negedge clk);
        if (ext_on) begin
            ext_ph = (ext_ph + 1 >= EXT_PER) ? 0 : ext_ph + 1;
            ext_ref = (ext_ph < EXT_PER / 2);
        end else begin
            ext_ph = 0;
            ext_ref = 1'b0;
        end
        if (bp_on) begin
            bp_ph = (bp_ph + 1 >= BP_PER) ? 0 : bp_ph + 1;
            tb_bp_clk = (bp_ph < BP_PER / 2);
        end else begin
            bp_ph = 0;
            tb_bp_clk = 1'b0;
        end
    end

    // R1 running model: stamp follows tick pulses; a drop to zero is a clear
    always @(negedge clk) begin
        if (mon_on) begin
            exp_ts = prev_tick ? prev_ts + 32'd1 : prev_ts;
            if (ts !== exp_ts) begin
                if (ts === 32'd0) clears++;
                else check(1'b0, "R1", ts, exp_ts);
            end
            if (tick) begin
                if (track && last_tick_cyc >= 0 && int'(cyc) - last_tick_cyc < min_gap)
                    min_gap = int'(cyc) - last_tick_cyc;
                last_tick_cyc = int'(cyc);
            end
            if (prev_bpt && !bp_trig_n_o) trig_falls++;
        end
        prev_tick = tick;
        prev_ts   = ts;
        prev_bpt  = bp_trig_n_o;
    end

    task automatic tick_gap(output int g);
        int t0;
        do @(negedge clk); while (tick !== 1'b1);
        t0 = int'(cyc);
        do @(negedge clk); while (tick !== 1'b1);
        g = int'(cyc) - t0;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (tick !== 1'b1);
        end
        @(negedge clk);
    endtask

    task automatic ext_pulse(input int w);
        @(negedge clk);
        ext_trig_n = 1'b0;
        repeat (w) @(negedge clk);
        ext_trig_n = 1'b1;
        repeat (30) @(negedge clk);
    endtask

    task automatic sw_pulse(input int h);
        @(negedge clk);
        sw_trig = 1'b1;
        repeat (h) @(negedge clk);
        sw_trig = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    task automatic trig_case(input string req, input bit use_ext, input int len, input int expc);
        int c0, f0;
        wait_ticks(2);
        c0 = clears;
        f0 = trig_falls;
        if (use_ext) ext_pulse(len);
        else sw_pulse(len);
        check(clears == c0 + expc, req, clears - c0, expc);
        check(trig_falls == f0 + expc, req, trig_falls - f0, expc);
    endtask

    initial begin
        int g, r, w;
        bit seen;
        r = $urandom(32'h5eed_0042);
        // R11 reset state
        repeat (4) @(negedge clk);
        check(ts == 32'd0, "R11", ts, 0);
        check(tick == 1'b0, "R11", tick, 0);
        check(ext_sel == 1'b0, "R11", ext_sel, 0);
        check(bp_clk_o == 1'b0, "R11", bp_clk_o, 0);
        check(bp_trig_n_o == 1'b1, "R11", bp_trig_n_o, 1);
        rst = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;
        check(master == 1'b1, "R9", master, 1);

        // R2 internal period
        track = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick_gap(g);
            check(g == TICK_DIV, "R2", g, TICK_DIV);
        end

        // R4 boundary widths, held-low level; R5 held software request
        trig_case("R4", 1'b1, TRIG_MIN - 1, 0);
        trig_case("R4", 1'b1, TRIG_MIN, 1);
        trig_case("R4", 1'b1, 200, 1);
        trig_case("R5", 1'b0, 1, 1);
        trig_case("R5", 1'b0, 40, 1);

        // R4/R5 random mix
        for (int i = 0; i < 12; i++) begin
            if ($urandom % 2 == 0) begin
                w = 20 + int'($urandom % 70);
                if (w >= 48 && w <= 52) w = 60;
                trig_case("R4", 1'b1, w, trig_expect(w));
            end else begin
                trig_case("R5", 1'b0, 1 + int'($urandom % 20), 1);
            end
        end

        // R6 acquire external reference
        ext_on = 1'b1;
        repeat (10 * EXT_PER) @(negedge clk);
        check(ext_sel == 1'b0, "R6", ext_sel, 0);
        seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (ext_sel) seen = 1'b1;
        end
        check(seen, "R6", seen, 1);
        tick_gap(g);
        tick_gap(g);
        check(g == EXT_PER, "R6", g, EXT_PER);
        tick_gap(g);
        check(g == EXT_PER, "R6", g, EXT_PER);

        // R7 loss and fallback
        ext_on = 1'b0;
        repeat (150) @(negedge clk);
        check(ext_sel == 1'b1, "R7", ext_sel, 1);
        repeat (150) @(negedge clk);
        check(ext_sel == 1'b0, "R7", ext_sel, 0);
        tick_gap(g);
        check(g == TICK_DIV, "R7", g, TICK_DIV);
        tick_gap(g);
        check(g == TICK_DIV, "R7", g, TICK_DIV);

        // R8 no shortened tick across both switches
        track = 1'b0;
        check(min_gap >= TICK_DIV / 2, "R8", min_gap, TICK_DIV / 2);

        // R9 / R10 slave board
        slot = 4'd5;
        slave_mode = 1'b1;
        bp_on = 1'b1;
        @(negedge clk);
        check(master == 1'b0, "R9", master, 0);
        begin
            int c0, f0;
            bit drove;
            wait_ticks(2);
            c0 = clears;
            f0 = trig_falls;
            drove = 1'b0;
            fork
                ext_pulse(80);
                sw_pulse(5);
                for (int i = 0; i < 150; i++) begin
                    @(negedge clk);
                    if (bp_clk_o !== 1'b0 || bp_trig_n_o !== 1'b1) drove = 1'b1;
                end
            join
            check(drove == 1'b0, "R10", drove, 0);
            check(clears == c0, "R10", clears - c0, 0);
            check(trig_falls == f0, "R10", trig_falls - f0, 0);
        end
        tick_gap(g);
        check(g == BP_PER, "R10", g, BP_PER);

        // R3 backplane trigger clears the stamp
        begin
            int c0;
            wait_ticks(2);
            c0 = clears;
            @(negedge clk);
            tb_bp_trig_n = 1'b0;
            repeat (3) @(negedge clk);
            tb_bp_trig_n = 1'b1;
            repeat (6) @(negedge clk);
            check(clears == c0 + 1, "R3", clears - c0, 1);
            check(ts <= 32'd1, "R3", ts, 0);
        end

        slot = 4'd11;
        @(negedge clk);
        check(master == 1'b0, "R9", master, 0);
        slot = 4'd3;
        @(negedge clk);
        check(master == 1'b1, "R9", master, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule